// File: doc/BRIEF.md
# Serial ADC Readout Controller

This controller runs on the host side of a two-channel, 10-bit serial converter that is read in external-clock mode with SPI mode 0 (clock idles low, data sampled on rising edges). A start request pulls chip-select low while the serial clock is held low. The controller then waits a fixed wake-up time and drives sixteen serial clock cycles. It can send these as one continuous run or as two bytes with an idle gap between them. Chip-select is raised once the last falling edge has passed, and a guard time must elapse before the next conversion can start.

The sixteen captured bits form a frame: three header ones, a channel bit, ten result bits with the most significant first, and two sub-bits. The controller splits the frame into these fields and presents them with a one-cycle strobe. It also raises a header error flag when the three header bits are not all one. The clock half-period, the wake-up time, the guard time and the byte gap are counts of system clock cycles given as parameters.

Top module: `adc_spi_reader`

## Requirements
- R1: Chip-select falls only while the serial clock is low, and the serial clock is low whenever chip-select is high.
- R2: The first serial clock rising edge comes exactly WAKE_CYC + HALF_CYC system cycles after chip-select falls.
- R3: Each conversion has exactly 16 rising edges. Each high phase and each low phase lasts HALF_CYC system cycles, so consecutive rising edges within a byte are 2*HALF_CYC cycles apart.
- R4: The data input is sampled once per rising edge. The first sampled bit is frame bit 15 and the last is frame bit 0.
- R5: With SPLIT=1, the 8th and 9th rising edges are 2*HALF_CYC + GAP_CYC cycles apart, and the clock stays low during the gap. With SPLIT=0 they are 2*HALF_CYC apart.
- R6: Chip-select rises one system cycle after the 16th falling edge. In that same cycle res_valid is high for exactly one cycle.
- R7: With res_valid, res_data holds frame bits 11..2 (bit 11 is the result MSB), res_chan holds frame bit 12, and res_sub holds frame bits 1..0.
- R8: hdr_err is 1 with res_valid when any of frame bits 15..13 is 0, and 0 when all three are 1. The other fields are reported in either case.
- R9: Chip-select stays high at least GUARD_CYC + 1 cycles between conversions. When start is held high, it stays high exactly that long.
- R10: start is ignored while busy is high. busy is high from the cycle chip-select falls until the guard time ends.
- R11: After reset, chip-select is high, the serial clock is low, and busy and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion when idle |
| busy | output | 1 | Conversion or guard time in progress |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock to the converter |
| miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle strobe marking new results |
| res_data | output | 10 | Conversion result |
| res_chan | output | 1 | Channel identification bit |
| res_sub | output | 2 | Sub-LSB bits |
| hdr_err | output | 1 | Header bits were not all one |

## Verification
A wrong state sequence or a misloaded timer shows up first in the cycle distances between edges. The gap from the chip-select fall to the first rising edge, each clock period, the byte gap and the chip-select high time are all measured to the exact cycle on every frame. A wrong bit counter shows up when chip-select rises with a rising-edge count other than sixteen, or when the strobe is out of step with it. A shift or field slip shows up in the fields returned for that same frame, because the test frames put distinct patterns at both ends of the result and in the header.

// File: rtl/adc_spi_reader.sv
module adc_spi_reader #(
  parameter int HALF_CYC  = 32,
  parameter int WAKE_CYC  = 320,
  parameter int GUARD_CYC = 8,
  parameter int GAP_CYC   = 16,
  parameter bit SPLIT     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       cs_n,
  output logic       sclk,
  input  logic       miso,
  output logic       res_valid,
  output logic [9:0] res_data,
  output logic       res_chan,
  output logic [1:0] res_sub,
  output logic       hdr_err
);
  localparam int MAXC = (WAKE_CYC > HALF_CYC ? WAKE_CYC : HALF_CYC) +
                        (GUARD_CYC > GAP_CYC ? GUARD_CYC : GAP_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_LO, S_HI, S_GAP, S_FIN, S_GUARD} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [3:0]  bitn;
  logic [15:0] shreg;

  wire tick = (cnt == '0);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= 1'b0;
      res_sub   <= '0;
      hdr_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cs_n <= 1'b0;
          bitn <= '0;
          cnt  <= CW'(WAKE_CYC - 1);
          st   <= S_WAKE;
        end
        S_WAKE, S_GAP: if (tick) begin
          cnt <= CW'(HALF_CYC - 1);
          st  <= S_LO;
        end else cnt <= cnt - 1'b1;
        S_LO: if (tick) begin
          sclk  <= 1'b1;
          shreg <= {shreg[14:0], miso};
          cnt   <= CW'(HALF_CYC - 1);
          st    <= S_HI;
        end else cnt <= cnt - 1'b1;
        S_HI: if (tick) begin
          sclk <= 1'b0;
          bitn <= bitn + 1'b1;
          if (bitn == 4'd15) st <= S_FIN;
          else if (SPLIT && bitn == 4'd7) begin
            cnt <= CW'(GAP_CYC - 1);
            st  <= S_GAP;
          end else begin
            cnt <= CW'(HALF_CYC - 1);
            st  <= S_LO;
          end
        end else cnt <= cnt - 1'b1;
        S_FIN: begin
          cs_n      <= 1'b1;
          res_valid <= 1'b1;
          res_data  <= shreg[11:2];
          res_chan  <= shreg[12];
          res_sub   <= shreg[1:0];
          hdr_err   <= ~&shreg[15:13];
          cnt       <= CW'(GUARD_CYC - 1);
          st        <= S_GUARD;
        end
        S_GUARD: if (tick) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_spi_reader_chk.sv
module adc_spi_reader_chk #(
  parameter int WAKE_CYC  = 320,
  parameter int GUARD_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic res_valid
);
  int   lo_cnt, hi_cnt, rises;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= GUARD_CYC;
      rises  <= 0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        lo_cnt <= 0;
        rises  <= 0;
        if (hi_cnt < GUARD_CYC + 2) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt <= 0;
        if (lo_cnt < WAKE_CYC + 2) lo_cnt <= lo_cnt + 1;
        if (sclk && !sclk_q) rises <= rises + 1;
      end
    end
  end

  a_r1_cs_fall_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  a_r1_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  a_r2_wake_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && rises == 0) |-> lo_cnt >= WAKE_CYC);
  a_r3_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> rises == 16);
  a_r6_valid_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r9_guard_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= GUARD_CYC);
endmodule

bind adc_spi_reader adc_spi_reader_chk #(.WAKE_CYC(WAKE_CYC), .GUARD_CYC(GUARD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .res_valid(res_valid));

// File: tb/sim_adc_spi_reader.sv
module adc_frame_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [15:0] frame,
  output logic        dout
);
  logic [15:0] sh;
  initial begin dout = 1'b1; sh = '0; end
  always @(negedge cs_n) begin sh = frame; dout = frame[15]; end
  always @(negedge sclk) if (!cs_n) begin sh = {sh[14:0], 1'b0}; dout = sh[15]; end
  always @(posedge cs_n) dout = 1'b1;
endmodule

module sim_adc_spi_reader;
  localparam int HALF = 4, WAKE = 20, GUARD = 6, GAP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic [15:0] f);
    return {~&f[15:13], f[12], f[11:2], f[1:0]};
  endfunction

  logic start0 = 0, cs0, sclk0, miso0, busy0, v0, c0, h0;
  logic [9:0] d0; logic [1:0] s0; logic [15:0] frame0 = '0;
  logic start1 = 0, cs1, sclk1, miso1, busy1, v1, c1, h1;
  logic [9:0] d1; logic [1:0] s1; logic [15:0] frame1 = '0;

  adc_spi_reader #(.HALF_CYC(HALF), .WAKE_CYC(WAKE), .GUARD_CYC(GUARD), .GAP_CYC(GAP), .SPLIT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .busy(busy0), .cs_n(cs0), .sclk(sclk0), .miso(miso0),
    .res_valid(v0), .res_data(d0), .res_chan(c0), .res_sub(s0), .hdr_err(h0));
  adc_spi_reader #(.HALF_CYC(HALF), .WAKE_CYC(WAKE), .GUARD_CYC(GUARD), .GAP_CYC(GAP), .SPLIT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .busy(busy1), .cs_n(cs1), .sclk(sclk1), .miso(miso1),
    .res_valid(v1), .res_data(d1), .res_chan(c1), .res_sub(s1), .hdr_err(h1));

  adc_frame_model m0 (.cs_n(cs0), .sclk(sclk0), .frame(frame0), .dout(miso0));
  adc_frame_model m1 (.cs_n(cs1), .sclk(sclk1), .frame(frame1), .dout(miso1));

  logic [13:0] q0[$], q1[$];

  // scoreboard monitors: R7, R8 fields, R6 no spurious strobe
  always @(negedge clk) if (rst_n && v0) begin
    if (q0.size() == 0) chk(1'b0, "R6 unexpected strobe u0", 1, 0);
    else begin
      logic [13:0] e; e = q0.pop_front();
      chk({h0, c0, d0, s0} == e, "R7/R8 fields u0", {h0, c0, d0, s0}, e);
    end
  end
  always @(negedge clk) if (rst_n && v1) begin
    if (q1.size() == 0) chk(1'b0, "R6 unexpected strobe u1", 1, 0);
    else begin
      logic [13:0] e; e = q1.pop_front();
      chk({h1, c1, d1, s1} == e, "R7 fields u1", {h1, c1, d1, s1}, e);
    end
  end

  // timing monitor for u0: R1 R2 R3 R5 R6 R9
  int cyc = 0, t_fall_cs = 0, t_rise_cs = -1, t_last_rise = 0, t_last_fall = 0, rises0 = 0;
  bit held = 0; logic pcs0 = 1, psclk0 = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pcs0 && !cs0) begin
        chk(sclk0 == 1'b0, "R1 sclk low at cs fall", sclk0, 0);
        if (t_rise_cs >= 0) begin
          if (held) chk(cyc - t_rise_cs == GUARD + 1, "R9 guard exact", cyc - t_rise_cs, GUARD + 1);
          else chk(cyc - t_rise_cs >= GUARD + 1, "R9 guard min", cyc - t_rise_cs, GUARD + 1);
        end
        t_fall_cs = cyc; rises0 = 0;
      end
      if (!psclk0 && sclk0) begin
        rises0++;
        if (rises0 == 1) chk(cyc - t_fall_cs == WAKE + HALF, "R2 wake", cyc - t_fall_cs, WAKE + HALF);
        else if (rises0 == 9) chk(cyc - t_last_rise == 2*HALF + GAP, "R5 split gap", cyc - t_last_rise, 2*HALF + GAP);
        else chk(cyc - t_last_rise == 2*HALF, "R3 period", cyc - t_last_rise, 2*HALF);
        t_last_rise = cyc;
      end
      if (psclk0 && !sclk0) t_last_fall = cyc;
      if (!pcs0 && cs0) begin
        chk(rises0 == 16, "R3 rise count", rises0, 16);
        chk(v0 == 1'b1, "R6 strobe with cs rise", v0, 1);
        chk(cyc - t_last_fall == 1, "R6 cs rise delay", cyc - t_last_fall, 1);
        chk(sclk0 == 1'b0, "R1 sclk low at cs rise", sclk0, 0);
        t_rise_cs = cyc; held = start0;
      end
    end
    pcs0 = cs0; psclk0 = sclk0;
  end

  // u1 continuous-mode gap: R5
  int r1n = 0, t1 = 0;
  logic pcs1 = 1, psclk1 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pcs1 && !cs1) r1n = 0;
      if (!psclk1 && sclk1) begin
        r1n++;
        if (r1n == 9) chk(cyc - t1 == 2*HALF, "R5 continuous gap", cyc - t1, 2*HALF);
        t1 = cyc;
      end
    end
    pcs1 = cs1; psclk1 = sclk1;
  end

  task automatic run0(input logic [15:0] f, input bit keep);
    frame0 = f; q0.push_back(mk(f)); start0 = 1;
    @(negedge clk);
    while (!v0) @(negedge clk);
    if (!keep) start0 = 0;
  endtask

  task automatic run1(input logic [15:0] f);
    frame1 = f; q1.push_back(mk(f)); start1 = 1;
    @(negedge clk); start1 = 0;
    while (!v1) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs0 == 1'b1, "R11 cs high", cs0, 1);
    chk(sclk0 == 1'b0, "R11 sclk low", sclk0, 0);
    chk(busy0 == 1'b0, "R11 busy low", busy0, 0);
    chk(v0 == 1'b0, "R11 valid low", v0, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R4 R7: back-to-back frames with start held (R9 exact)
    run0({3'b111, 1'b0, 10'h3FF, 2'b11}, 1);
    run0({3'b111, 1'b1, 10'h000, 2'b00}, 1);
    run0({3'b111, 1'b1, 10'h2A5, 2'b10}, 0);
    repeat (GUARD + 3) @(negedge clk);
    // R8 header errors
    run0({3'b110, 1'b0, 10'h155, 2'b01}, 0);
    repeat (GUARD + 3) @(negedge clk);
    run0({3'b011, 1'b1, 10'h201, 2'b10}, 0);
    repeat (GUARD + 3) @(negedge clk);
    // R10 start ignored while busy
    frame0 = {3'b111, 1'b0, 10'h0C3, 2'b01}; q0.push_back(mk(frame0));
    start0 = 1; @(negedge clk); start0 = 0;
    chk(busy0 == 1'b1, "R10 busy after start", busy0, 1);
    repeat (5) @(negedge clk);
    start0 = 1; @(negedge clk); start0 = 0;
    while (!v0) @(negedge clk);
    start0 = 1; @(negedge clk); start0 = 0;
    repeat (GUARD + 4) @(negedge clk);
    chk(busy0 == 1'b0, "R10 no extra conversion busy", busy0, 0);
    chk(cs0 == 1'b1, "R10 no extra conversion cs", cs0, 1);
    // continuous mode
    run1({3'b111, 1'b1, 10'h1E7, 2'b11});
    repeat (GUARD + 3) @(negedge clk);
    run1({3'b111, 1'b0, 10'h001, 2'b00});
    repeat (GUARD + 3) @(negedge clk);
    chk(q0.size() == 0, "R6 all u0 results seen", q0.size(), 0);
    chk(q1.size() == 0, "R6 all u1 results seen", q1.size(), 0);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end
endmodule